// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block is the read side of a serial memory that feeds a stored bitstream to a programmable logic device that loads itself as a serial master. The bitstream is held in an internal array of words. A synchronous write port fills the array while the block is in programming mode. In read mode the block presents one stored bit at a time on its serial output, starting from the most significant bit of each word. The consumer's clock pulls the next bit by accepting the current one.

Several instances can be chained. An active-low chip-enable input selects a device. Its chip-enable-out goes low once the device's last bit has been taken, and that low selects the next device in the chain. A reset/output-enable input clears the bit counter. The level at which it counts as active is chosen by a polarity input. A power-on window holds the block quiet for a fixed number of cycles after reset, and a ready pull-down output is asserted during that window.

The serial output follows valid/ready rules. `dout_valid` stands for the output driver being enabled: when it is low the line is treated as high impedance and `dout` reads 0. A bit is consumed on a rising clock edge where `dout_valid` and `bit_ready` are both high. While `bit_ready` is low, the current bit and the counter are held for as long as the consumer wants. The block never withdraws a bit for flow-control reasons. It withdraws a bit only for standby, programming mode, reset/output-enable, the power-on window or end of memory.

Top module: `cfgmem_reader`

## Requirements
- R1: For `POR_CYCLES` rising edges after `rst_n` is released, `ready_pull` is 1, `dout_valid` is 0 and the counter stays at bit 0. After that, `ready_pull` is 0. While `rst_n` is low, `ready_pull` is 1, `dout_valid` is 0 and `ceo_n` is 1.
- R2: The array is read as words of `WORD_W` bits. Bit index i is bit (`WORD_W`-1 - i mod `WORD_W`) of word i / `WORD_W`, so each word is sent most significant bit first. The counter moves one bit forward only on an edge where `dout_valid` and `bit_ready` are both 1. Otherwise the bit and the counter are held.
- R3: Once bit `DEPTH_BITS`-1 has been taken, `dout_valid` goes to 0 and `ceo_n` goes to 0.
- R4: When two instances are chained with the first device's `ceo_n` driving the second device's `ce_n`, exactly one of them is valid in every cycle until both are exhausted. The second device starts at its own bit 0 in the cycle right after the first device's last bit is taken.
- R5: While reset/output-enable is active, `dout_valid` is 0 and `ceo_n` is 1, and the next edge returns the counter to bit 0 and clears the end-of-memory state.
- R6: With `rst_pol_hi`=0, reset/output-enable is active when `rst_oe`=0. With `rst_pol_hi`=1, it is active when `rst_oe`=1. The inactive level has no effect on the counter.
- R7: While `ce_n`=1 (standby), `dout_valid` is 0 whatever the state of `rst_oe`, and the counter does not move.
- R8: While `run_en`=0 (programming mode), `dout_valid` is 0, the counter does not move, and `wr_en` writes `wr_data` into word `wr_addr`. Writes attempted while `run_en`=1 are ignored.
- R9: With reset/output-enable held inactive after the end of memory, `ceo_n` stays 0 and `dout_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; the bit counter moves on its rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pol_hi | input | 1 | Polarity setting for `rst_oe`: 1 = active high, 0 = active low |
| rst_oe | input | 1 | Reset/output-enable input |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| run_en | input | 1 | 1 = serial read mode, 0 = programming mode |
| wr_en | input | 1 | Word write strobe (programming mode only) |
| wr_addr | input | $clog2(DEPTH_BITS/WORD_W) | Word address for writes |
| wr_data | input | WORD_W | Word written into the array |
| bit_ready | input | 1 | Consumer accepts the current bit |
| dout | output | 1 | Serial data bit (0 while the driver is off) |
| dout_valid | output | 1 | Output driver enabled; the bit on `dout` is valid |
| ceo_n | output | 1 | Chip-enable-out to the next device, low after end of memory |
| ready_pull | output | 1 | Ready pull-down enable, 1 during the power-on window |

## Verification
The hardest condition to reach from the ports is the hand-over between two chained devices. The upstream device has to be walked through every one of its bits while the consumer throttles it irregularly, and then the cycle right after its last accepted bit has to be observed. The bench chains two instances and feeds `bit_ready` a repeating three-cycle pattern that holds every third cycle. It then sweeps the whole combined stream one cycle at a time, checking each bit, that exactly one device drives, and that no cycle is lost at the boundary. Held state under standby and programming mode is reached by stopping partway through a word, switching mode while `bit_ready` stays high, and then checking that the stream resumes at the same bit index.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  // Resolve the programmable polarity of the reset/output-enable pin.
  function automatic logic oe_is_active(input logic pol_hi, input logic pin);
    return pol_hi ? pin : ~pin;
  endfunction
endpackage

// File: rtl/cfgmem_por.sv
module cfgmem_por #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          busy_q;

  // Busy from reset through the CYCLES-th rising edge after release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt == CW'(CYCLES - 1)) busy_q <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
  parameter int unsigned DEPTH_BITS = 256,
  parameter int unsigned WORD_W     = 8
) (
  input  logic                                  clk,
  input  logic                                  wr_en,
  input  logic [$clog2(DEPTH_BITS/WORD_W)-1:0]  wr_addr,
  input  logic [WORD_W-1:0]                     wr_data,
  input  logic [$clog2(DEPTH_BITS)-1:0]         rd_addr,
  output logic                                  rd_bit
);
  localparam int unsigned NWORDS = DEPTH_BITS / WORD_W;
  localparam int unsigned WAW    = $clog2(NWORDS);
  localparam int unsigned AW     = $clog2(DEPTH_BITS);
  localparam int unsigned BW     = $clog2(WORD_W);

  logic [WORD_W-1:0] words [NWORDS];
  logic [WORD_W-1:0] sel_word;

  // One write decoder per word.
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && wr_addr == WAW'(w)) words[w] <= wr_data;
    end
  end

  // Word select from upper address bits; inverted low bits give MSB-first order.
  assign sel_word = words[rd_addr[AW-1:BW]];
  assign rd_bit   = sel_word[~rd_addr[BW-1:0]];
endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq #(
  parameter int unsigned DEPTH_BITS = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          step,
  output logic [$clog2(DEPTH_BITS)-1:0] addr,
  output logic                          done
);
  localparam int unsigned AW = $clog2(DEPTH_BITS);
  localparam logic [AW-1:0] LAST = AW'(DEPTH_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      done <= 1'b0;
    end else if (clear) begin
      addr <= '0;
      done <= 1'b0;
    end else if (step && !done) begin
      if (addr == LAST) done <= 1'b1;   // stay on the last bit
      else              addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/cfgmem_reader.sv
module cfgmem_reader #(
  parameter int unsigned DEPTH_BITS = 256,
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rst_pol_hi,
  input  logic                                 rst_oe,
  input  logic                                 ce_n,
  input  logic                                 run_en,
  input  logic                                 wr_en,
  input  logic [$clog2(DEPTH_BITS/WORD_W)-1:0] wr_addr,
  input  logic [WORD_W-1:0]                    wr_data,
  input  logic                                 bit_ready,
  output logic                                 dout,
  output logic                                 dout_valid,
  output logic                                 ceo_n,
  output logic                                 ready_pull
);
  import cfgmem_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH_BITS);

  logic          oe_act;
  logic          por_busy;
  logic          take;
  logic          rd_bit;
  logic [AW-1:0] seq_addr;
  logic          seq_done;

  assign oe_act = oe_is_active(rst_pol_hi, rst_oe);

  cfgmem_por #(.CYCLES(POR_CYCLES)) u_por (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (por_busy)
  );

  cfgmem_seq #(.DEPTH_BITS(DEPTH_BITS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (por_busy || oe_act),
    .step  (take),
    .addr  (seq_addr),
    .done  (seq_done)
  );

  cfgmem_store #(.DEPTH_BITS(DEPTH_BITS), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en && !run_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (seq_addr),
    .rd_bit  (rd_bit)
  );

  // Driver enabled only when selected, in read mode, out of reset and not exhausted.
  assign dout_valid = !por_busy && !ce_n && run_en && !oe_act && !seq_done;
  assign take       = dout_valid && bit_ready;
  assign dout       = dout_valid & rd_bit;
  assign ceo_n      = !(seq_done && !oe_act);
  assign ready_pull = por_busy;
endmodule

// File: rtl/cfgmem_reader_chk.sv
module cfgmem_reader_chk #(
  parameter int unsigned DEPTH_BITS = 256
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rst_pol_hi,
  input logic                          rst_oe,
  input logic                          ce_n,
  input logic                          run_en,
  input logic                          bit_ready,
  input logic                          dout_valid,
  input logic                          ceo_n,
  input logic                          ready_pull,
  input logic [$clog2(DEPTH_BITS)-1:0] seq_addr,
  input logic                          seq_done
);
  localparam int unsigned AW = $clog2(DEPTH_BITS);
  localparam logic [AW-1:0] LAST = AW'(DEPTH_BITS - 1);

  logic oe_act;
  assign oe_act = rst_pol_hi ? rst_oe : !rst_oe;

  a_r1_silent_por: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pull |-> (!dout_valid && seq_addr == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dout_valid && bit_ready) && !oe_act) |=> $stable(seq_addr));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && bit_ready && seq_addr != LAST) |=> (seq_addr == AW'($past(seq_addr) + 1'b1)));

  a_r3_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ceo_n |-> !dout_valid);

  a_r5_oe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    oe_act |=> (seq_addr == '0 && !seq_done));

  a_r5_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    oe_act |-> (ceo_n && !dout_valid));

  a_r7_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_valid);

  a_r8_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !dout_valid);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !oe_act) |=> seq_done);
endmodule

bind cfgmem_reader cfgmem_reader_chk #(.DEPTH_BITS(DEPTH_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_pol_hi (rst_pol_hi),
  .rst_oe     (rst_oe),
  .ce_n       (ce_n),
  .run_en     (run_en),
  .bit_ready  (bit_ready),
  .dout_valid (dout_valid),
  .ceo_n      (ceo_n),
  .ready_pull (ready_pull),
  .seq_addr   (seq_addr),
  .seq_done   (seq_done)
);

// File: tb/tb_cfgmem_reader.sv
module tb_cfgmem_reader;
  localparam int DEPTH = 64;
  localparam int WW    = 8;
  localparam int NW    = DEPTH / WW;
  localparam int P     = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rst_pol_hi, rst_oe, ce_n, run_en, bit_ready;
  logic wr_en0, wr_en1;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic d0, v0, ceo0, rp0, d1, v1, ceo1, rp1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] model [2][NW];

  cfgmem_reader #(.DEPTH_BITS(DEPTH), .WORD_W(WW), .POR_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .rst_pol_hi(rst_pol_hi), .rst_oe(rst_oe),
    .ce_n(ce_n), .run_en(run_en), .wr_en(wr_en0), .wr_addr(wr_addr),
    .wr_data(wr_data), .bit_ready(bit_ready), .dout(d0), .dout_valid(v0),
    .ceo_n(ceo0), .ready_pull(rp0));

  cfgmem_reader #(.DEPTH_BITS(DEPTH), .WORD_W(WW), .POR_CYCLES(P)) dut_nxt (
    .clk(clk), .rst_n(rst_n), .rst_pol_hi(rst_pol_hi), .rst_oe(rst_oe),
    .ce_n(ceo0), .run_en(run_en), .wr_en(wr_en1), .wr_addr(wr_addr),
    .wr_data(wr_data), .bit_ready(bit_ready), .dout(d1), .dout_valid(v1),
    .ceo_n(ceo1), .ready_pull(rp1));

  function automatic logic expbit(input int dev, input int idx);
    logic [7:0] w;
    w = model[dev][idx / WW];
    return w[WW - 1 - (idx % WW)];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int g;
    int cyc;
    rst_n = 0; rst_pol_hi = 0; rst_oe = 1; ce_n = 0; run_en = 0;
    bit_ready = 0; wr_en0 = 0; wr_en1 = 0; wr_addr = '0; wr_data = '0;

    // Preload both devices in programming mode (R8 write path).
    for (int w = 0; w < NW; w++) begin
      model[0][w] = 8'((w * 37 + 11) & 255);
      model[1][w] = 8'((w * 91 + 5) & 255);
    end
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      wr_addr = 3'(w); wr_data = model[0][w]; wr_en0 = 1; wr_en1 = 0;
      @(negedge clk);
      wr_data = model[1][w]; wr_en0 = 0; wr_en1 = 1;
    end
    @(negedge clk);
    wr_en1 = 0;
    #1;
    chk("R1 ready_pull in reset", 32'(rp0), 1);
    chk("R1 valid in reset", 32'(v0), 0);
    chk("R1 ceo_n in reset", 32'(ceo0), 1);

    // R1: power-on window with bit_ready high.
    run_en = 1; bit_ready = 1;
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < P; k++) begin
      #1;
      chk("R1 ready_pull during window", 32'(rp0), 1);
      chk("R1 valid during window", 32'(v0), 0);
      @(negedge clk);
    end
    #1;
    chk("R1 ready_pull after window", 32'(rp0), 0);
    chk("R1 valid after window", 32'(v0), 1);
    chk("R1 counter held at bit 0", 32'(d0), 32'(expbit(0, 0)));

    // R2/R4: full chained stream with throttled ready.
    g = 0; cyc = 0;
    while (g < 2 * DEPTH && cyc < 400) begin
      bit_ready = (cyc % 3 != 2);
      #1;
      chk("R4 exactly one driver", 32'(v0) + 32'(v1), 1);
      chk("R4 active device", 32'(v1), 32'(g / DEPTH));
      chk("R2 stream bit", 32'(v0 ? d0 : d1), 32'(expbit(g / DEPTH, g % DEPTH)));
      @(negedge clk);
      if (bit_ready) g++;
      cyc++;
    end
    bit_ready = 1;
    #1;
    chk("R3 upstream quiet at end", 32'(v0), 0);
    chk("R3 upstream ceo_n low", 32'(ceo0), 0);
    chk("R3 downstream quiet at end", 32'(v1), 0);
    chk("R3 downstream ceo_n low", 32'(ceo1), 0);

    // R9: inactive reset level leaves end state in place.
    repeat (5) @(negedge clk);
    #1;
    chk("R9 ceo_n stays low", 32'(ceo0), 0);
    chk("R9 valid stays low", 32'(v0), 0);

    // R5: active-low pulse (polarity 0).
    rst_oe = 0;
    #1;
    chk("R5 valid off while active", 32'(v0), 0);
    chk("R5 ceo_n high while active", 32'(ceo0), 1);
    chk("R5 downstream ceo_n high", 32'(ceo1), 1);
    @(negedge clk);
    rst_oe = 1;
    #1;
    chk("R5 restart valid", 32'(v0), 1);
    chk("R5 restart at bit 0", 32'(d0), 32'(expbit(0, 0)));
    chk("R5 downstream idle", 32'(v1), 0);
    repeat (5) @(negedge clk);
    #1;
    chk("R5 advanced to bit 5", 32'(d0), 32'(expbit(0, 5)));

    // R6: switch to active-high; the low level is now inactive.
    bit_ready = 0; rst_pol_hi = 1; rst_oe = 0;
    #1;
    chk("R6 low level inactive valid", 32'(v0), 1);
    chk("R6 low level keeps counter", 32'(d0), 32'(expbit(0, 5)));
    @(negedge clk);
    #1;
    chk("R6 counter kept after edge", 32'(d0), 32'(expbit(0, 5)));
    rst_oe = 1;
    #1;
    chk("R6 high level active", 32'(v0), 0);
    @(negedge clk);
    rst_oe = 0;
    #1;
    chk("R6 high level cleared counter", 32'(d0), 32'(expbit(0, 0)));
    chk("R6 valid after release", 32'(v0), 1);

    // R7: standby in the middle of a word.
    bit_ready = 1;
    repeat (3) @(negedge clk);
    ce_n = 1;
    #1;
    chk("R7 standby valid", 32'(v0), 0);
    chk("R7 standby ceo_n", 32'(ceo0), 1);
    repeat (4) @(negedge clk);
    #1;
    chk("R7 standby still quiet", 32'(v0), 0);
    ce_n = 0;
    #1;
    chk("R7 resumes at held bit", 32'(d0), 32'(expbit(0, 3)));
    chk("R7 valid after standby", 32'(v0), 1);

    // R8: programming mode holds counter and accepts writes.
    run_en = 0;
    #1;
    chk("R8 programming valid", 32'(v0), 0);
    wr_en0 = 1; wr_addr = 3'd0; wr_data = 8'hA5;
    @(negedge clk);
    wr_en0 = 0;
    model[0][0] = 8'hA5;
    repeat (3) @(negedge clk);
    bit_ready = 0;
    run_en = 1;
    #1;
    chk("R8 counter held", 32'(d0), 32'(expbit(0, 3)));
    chk("R8 valid after programming", 32'(v0), 1);
    wr_en0 = 1; wr_addr = 3'd0; wr_data = 8'h3C;
    @(negedge clk);
    wr_en0 = 0;
    rst_oe = 1;
    @(negedge clk);
    rst_oe = 0; bit_ready = 1;
    for (int i = 0; i < WW; i++) begin
      #1;
      chk("R8 word after ignored write", 32'(d0), 32'(expbit(0, i)));
      @(negedge clk);
    end

    finish_run();
  end
endmodule